// File: doc/BRIEF.md
# Multi-Channel Waveform Playback Source

This block stores sample waveforms in a separate on-chip memory for each output channel and plays them out, over and over, on stream master interfaces. Software loads samples into each channel's buffer, programs how many samples make up one waveform period, and chooses per channel whether the buffer is being loaded or played. All of this goes through a simple write port on a control clock. Playback runs on a separate stream clock. There, each channel walks an address counter through its buffer, one sample per accepted transfer, and returns to the first sample after the programmed length.

The play and enable masks reach the stream clock through two-flop synchronisers. The sample count is not handshaked: it is a quasi-static setting that software changes only while playback is stopped, and the stream-side counters read it directly. Channel `i` is stream lane `i`. Lanes are numbered consecutively from zero.

Top module: `wave_playback_src`

## Requirements
- R1: After reset, every `m_tvalid` bit is low, all channels are in load mode, all enables are clear and the sample count register is zero.
- R2: A write with `ctl_addr[ADDR_W-1]=1` stores `ctl_wdata[SAMPLE_W-1:0]` into the buffer of channel `ctl_addr[WORD_W +: CH_W]` at word `ctl_addr[WORD_W-1:0]`. Other channels are left untouched.
- R3: A buffer write aimed at a channel whose play bit is set has no effect on that buffer. A write to a channel in load mode takes effect even while other channels play.
- R4: When a channel enters play mode, its first transferred sample is word 0. Each later transfer carries the next word in order.
- R5: After the transfer of word `L-1`, the next transfer carries word 0 again. `L` is the sample count register (register-space `ctl_addr[1:0]=0`, bits `CNT_W-1:0`), except that a count of 0 acts as 1 and a count above `DEPTH` acts as `DEPTH`.
- R6: A channel's `tdata` and its position in the waveform advance only on a cycle where its `tvalid` and `tready` are both high. While `tready` is low, `tdata` holds.
- R7: Clearing a channel's enable bit (register-space `ctl_addr[1:0]=2`, bit `i` for channel `i`) drives that channel's `tvalid` low. Its position freezes, and playback resumes from the same word when the bit is set again.
- R8: A channel whose play bit (register-space `ctl_addr[1:0]=1`, bit `i`) is clear keeps `tvalid` low. Setting the bit restarts the channel at word 0.
- R9: Channel `i` drives `m_tdata[i*SAMPLE_W +: SAMPLE_W]`, `m_tvalid[i]` and reads `m_tready[i]`. Each channel runs independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock |
| ctl_rst | input | 1 | Synchronous active-high reset, control domain |
| ctl_we | input | 1 | Write strobe for register or buffer access |
| ctl_addr | input | ADDR_W | Bit ADDR_W-1 selects buffer space; otherwise bits 1:0 select a register |
| ctl_wdata | input | DATA_W | Write data |
| strm_clk | input | 1 | Stream clock |
| strm_rst | input | 1 | Synchronous active-high reset, stream domain |
| m_tdata | output | NUM_CH*SAMPLE_W | Packed sample lanes, channel 0 in the low bits |
| m_tvalid | output | NUM_CH | Per-channel valid |
| m_tready | input | NUM_CH | Per-channel ready from the consumer |

## Verification
A faulty address counter shows up at the ports on the very next accepted transfer: the sample on `tdata` no longer matches the word the bench expects, whether the fault is a wrong start point, an early or late wrap, or a step taken without a handshake. A bad write gate corrupts a buffer silently, so it becomes visible only when that word is next played, at most one waveform period later. Gating faults show as `tvalid` high on a channel that is stopped or disabled, a few stream cycles after the control write once the synchronisers have settled.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    // register-space selector, taken from ctl_addr[1:0]
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PLAY   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     is_mem;
        reg_sel_e sel;
    } ctl_op_t;

    // effective waveform length: 0 acts as 1, oversize acts as depth
    function automatic int unsigned clamp_count(input int unsigned raw,
                                                input int unsigned depth);
        if (raw == 0)
            return 1;
        else if (raw > depth)
            return depth;
        else
            return raw;
    endfunction

    // successor of idx within a waveform of lim samples
    function automatic int unsigned next_index(input int unsigned idx,
                                               input int unsigned lim);
        if (idx + 1 >= lim)
            return 0;
        else
            return idx + 1;
    endfunction

endpackage

// File: rtl/wpb_bit_sync.sv
module wpb_bit_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wpb_ctl_regs.sv
module wpb_ctl_regs
    import wpb_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DEPTH    = 256,
    parameter int SAMPLE_W = 16,
    parameter int DATA_W   = 32,
    parameter int CH_W     = 2,
    parameter int WORD_W   = 8,
    parameter int CNT_W    = 9,
    parameter int ADDR_W   = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [CNT_W-1:0]    count_q,
    output logic [NUM_CH-1:0]   play_q,
    output logic [NUM_CH-1:0]   en_q,
    output logic [NUM_CH-1:0]   mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_data
);
    ctl_op_t           op;
    logic [CH_W-1:0]   ch_sel;
    logic              unused_bits;

    assign unused_bits = ^wdata;
    assign ch_sel      = addr[WORD_W +: CH_W];
    assign mem_addr    = addr[WORD_W-1:0];
    assign mem_data    = wdata[SAMPLE_W-1:0];

    always_comb begin
        op.is_mem = addr[ADDR_W-1];
        op.sel    = op.is_mem ? SEL_NONE : reg_sel_e'(addr[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            play_q  <= '0;
            en_q    <= '0;
        end else if (we) begin
            unique case (op.sel)
                SEL_COUNT:  count_q <= wdata[CNT_W-1:0];
                SEL_PLAY:   play_q  <= wdata[NUM_CH-1:0];
                SEL_ENABLE: en_q    <= wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    // buffer write gate: a playing channel refuses new samples
    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign mem_we[c] = we && op.is_mem && (int'(ch_sel) == c) && !play_q[c];
    end

    // R2
    mem_we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_we));

    // R3
    no_write_playing_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we & play_q) == '0);

endmodule

// File: rtl/wpb_chan.sv
module wpb_chan
    import wpb_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int SAMPLE_W = 16,
    parameter int WORD_W   = 8,
    parameter int CNT_W    = 9
) (
    input  logic                wclk,
    input  logic                we,
    input  logic [WORD_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic                sclk,
    input  logic                srst,
    input  logic                run,
    input  logic                en,
    input  logic [CNT_W-1:0]    count,
    input  logic                tready,
    output logic                tvalid,
    output logic [SAMPLE_W-1:0] tdata
);
    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [SAMPLE_W-1:0] q;
    logic [WORD_W-1:0]   cnt;
    logic [WORD_W-1:0]   nxt;
    logic [WORD_W-1:0]   rd_addr;
    logic [CNT_W-1:0]    lim;
    logic                primed;
    logic                fire;

    // count crosses without a handshake: it is only changed while stopped
    assign lim  = CNT_W'(clamp_count(32'(count), DEPTH));
    assign nxt  = WORD_W'(next_index(32'(cnt), 32'(lim)));

    assign tvalid  = primed && en;
    assign fire    = tvalid && tready;
    assign rd_addr = fire ? nxt : cnt;
    assign tdata   = q;

    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // read ahead so q always holds the word at the current position
    always_ff @(posedge sclk) begin
        q <= mem[rd_addr];
    end

    always_ff @(posedge sclk) begin
        if (srst || !run) begin
            cnt    <= '0;
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
            if (fire)
                cnt <= nxt;
        end
    end

    // R4
    start_at_zero_chk: assert property (@(posedge sclk) disable iff (srst)
        $rose(run) |-> (cnt == '0));

    // R5
    cnt_in_range_chk: assert property (@(posedge sclk) disable iff (srst)
        ({1'b0, cnt} < {1'b0, lim}));

    // R6
    hold_data_chk: assert property (@(posedge sclk) disable iff (srst)
        (tvalid && !tready) |=> ($stable(tdata) || !tvalid));

    // R6
    cnt_hold_chk: assert property (@(posedge sclk) disable iff (srst)
        (run && !fire) |=> $stable(cnt));

    // R6
    cnt_step_chk: assert property (@(posedge sclk) disable iff (srst)
        (run && fire && lim > 1) |=> (cnt != $past(cnt)));

    // R8
    stopped_quiet_chk: assert property (@(posedge sclk) disable iff (srst)
        !run |=> !tvalid);

endmodule

// File: rtl/wave_playback_src.sv
module wave_playback_src
    import wpb_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DEPTH    = 256,
    parameter int SAMPLE_W = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 1 + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1) + $clog2(DEPTH)
) (
    input  logic                       ctl_clk,
    input  logic                       ctl_rst,
    input  logic                       ctl_we,
    input  logic [ADDR_W-1:0]          ctl_addr,
    input  logic [DATA_W-1:0]          ctl_wdata,
    input  logic                       strm_clk,
    input  logic                       strm_rst,
    output logic [NUM_CH*SAMPLE_W-1:0] m_tdata,
    output logic [NUM_CH-1:0]          m_tvalid,
    input  logic [NUM_CH-1:0]          m_tready
);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WORD_W = $clog2(DEPTH);
    localparam int CNT_W  = WORD_W + 1;

    logic [CNT_W-1:0]    count_q;
    logic [NUM_CH-1:0]   play_q;
    logic [NUM_CH-1:0]   en_q;
    logic [NUM_CH-1:0]   mem_we;
    logic [WORD_W-1:0]   mem_addr;
    logic [SAMPLE_W-1:0] mem_data;
    logic [NUM_CH-1:0]   play_s;
    logic [NUM_CH-1:0]   en_s;

    wpb_ctl_regs #(
        .NUM_CH(NUM_CH), .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .DATA_W(DATA_W),
        .CH_W(CH_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(ctl_clk), .rst(ctl_rst), .we(ctl_we), .addr(ctl_addr),
        .wdata(ctl_wdata), .count_q(count_q), .play_q(play_q), .en_q(en_q),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    wpb_bit_sync #(.W(NUM_CH)) u_play_sync (
        .clk(strm_clk), .rst(strm_rst), .d(play_q), .q(play_s)
    );

    wpb_bit_sync #(.W(NUM_CH)) u_en_sync (
        .clk(strm_clk), .rst(strm_rst), .d(en_q), .q(en_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wpb_chan #(
            .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
        ) u_chan (
            .wclk(ctl_clk), .we(mem_we[c]), .waddr(mem_addr), .wdata(mem_data),
            .sclk(strm_clk), .srst(strm_rst), .run(play_s[c]), .en(en_s[c]),
            .count(count_q), .tready(m_tready[c]), .tvalid(m_tvalid[c]),
            .tdata(m_tdata[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    // R7
    disabled_quiet_chk: assert property (@(posedge strm_clk) disable iff (strm_rst)
        $fell(en_s) == '0 || ((m_tvalid & ~en_s) == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge strm_clk)
        $past(strm_rst) |-> (m_tvalid == '0));

endmodule

// File: tb/sim_wave_playback_src.sv
module sim_wave_playback_src;
    localparam int NCH = 4;
    localparam int DEP = 256;
    localparam int SW  = 16;

    logic        ctl_clk = 0, strm_clk = 0;
    logic        ctl_rst = 1, strm_rst = 1;
    logic        ctl_we = 0;
    logic [10:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [NCH*SW-1:0] m_tdata;
    logic [NCH-1:0]    m_tvalid;
    logic [NCH-1:0]    m_tready = '0;

    int errors = 0, checks = 0;
    bit done = 0;
    bit mon_on = 0;
    string tag = "R4";
    int rdy_pct = 100;
    logic [SW-1:0] ref_mem [NCH][DEP];
    int exp_idx [NCH];
    int lim_m = 1;
    logic [NCH-1:0] play_m = '0, en_m = '0, quiet = '1;

    always #5 ctl_clk = ~ctl_clk;
    initial begin #3; forever #5 strm_clk = ~strm_clk; end

    wave_playback_src u0 (
        .ctl_clk(ctl_clk), .ctl_rst(ctl_rst), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .strm_clk(strm_clk), .strm_rst(strm_rst),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    function automatic int exp_lim(input int raw);
        if (raw == 0) return 1;
        if (raw > DEP) return DEP;
        return raw;
    endfunction

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    always @(posedge strm_clk) begin
        #2;
        for (int c = 0; c < NCH; c++)
            m_tready[c] <= (($urandom % 100) < rdy_pct);
    end

    // monitor: R4 R5 R6 R9 data order, R7 R8 quiet lanes
    always @(negedge strm_clk) begin
        if (mon_on) begin
            for (int c = 0; c < NCH; c++) begin
                if (quiet[c]) begin
                    check(!m_tvalid[c], {tag, " R7 R8 quiet lane"}, m_tvalid[c], 0);
                end else if (m_tvalid[c]) begin
                    check(m_tdata[c*SW +: SW] == ref_mem[c][exp_idx[c]],
                          {tag, " R4 R5 R6 R9 sample"},
                          m_tdata[c*SW +: SW], ref_mem[c][exp_idx[c]]);
                    if (m_tready[c])
                        exp_idx[c] = (exp_idx[c] + 1 >= lim_m) ? 0 : exp_idx[c] + 1;
                end
            end
        end
    end

    task automatic ctl_wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge ctl_clk);
        ctl_we = 1; ctl_addr = a; ctl_wdata = d;
        @(negedge ctl_clk);
        ctl_we = 0;
    endtask

    task automatic buf_wr(input int ch, input int w, input logic [SW-1:0] d);
        ctl_wr(11'(1024 + ch * DEP + w), {16'hdead, d});
        if (!play_m[ch]) ref_mem[ch][w] = d;   // R3 model: writes to playing channel dropped
    endtask

    task automatic load(input int ch, input int n);
        for (int w = 0; w < n; w++) buf_wr(ch, w, 16'($urandom));
    endtask

    task automatic set_ctl(input logic [NCH-1:0] p, input logic [NCH-1:0] e);
        quiet = quiet & ~(p & e);
        play_m = p; en_m = e;
        ctl_wr(11'd1, 32'(p));
        ctl_wr(11'd2, 32'(e));
        repeat (8) @(negedge strm_clk);
        for (int c = 0; c < NCH; c++)
            if (!p[c]) exp_idx[c] = 0;
        quiet = ~(p & e);
    endtask

    task automatic set_count(input int n);
        ctl_wr(11'd0, 32'(n));
        lim_m = exp_lim(n);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge strm_clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < NCH; c++) exp_idx[c] = 0;
        repeat (4) @(negedge ctl_clk);
        ctl_rst = 0; strm_rst = 0;
        @(negedge strm_clk);
        // R1: no valid after reset
        check(m_tvalid == '0, "R1 reset tvalid", m_tvalid, 0);
        mon_on = 1;
        run(5);
        check(m_tvalid == '0, "R1 idle tvalid", m_tvalid, 0);

        tag = "R2 R9";
        for (int c = 0; c < NCH; c++) load(c, DEP);
        set_count(5);
        rdy_pct = 70;
        set_ctl('1, '1);
        run(150);

        tag = "R6";
        rdy_pct = 0;  run(30);
        rdy_pct = 100; run(30);

        tag = "R3";
        for (int w = 0; w < 5; w++) buf_wr(0, w, ~ref_mem[0][w]);
        rdy_pct = 80; run(60);

        tag = "R7";
        set_ctl('1, 4'b1011);
        run(60);
        set_ctl('1, '1);
        run(60);

        tag = "R5 full";
        set_ctl('0, '1);
        set_count(DEP);
        rdy_pct = 90;
        set_ctl('1, '1);
        run(700);

        tag = "R5 zero";
        set_ctl('0, '1);
        set_count(0);
        set_ctl('1, '1);
        run(40);

        tag = "R5 over";
        set_ctl('0, '1);
        set_count(DEP + 44);
        set_ctl('1, '1);
        run(320);

        tag = "R8";
        set_ctl('0, '1);
        set_count(7);
        set_ctl(4'b0101, '1);
        run(80);
        tag = "R3 load idle";
        for (int w = 0; w < 7; w++) buf_wr(1, w, 16'($urandom));
        set_ctl('1, '1);
        run(80);

        done = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge ctl_clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end
endmodule